// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects interrupt requests from `NSRC` sources for a small processor core. It tells the core whether an interrupt should be taken now and which vector index to use. The `LEVEL_MASK` parameter sets the type of each source:

- An event source records each pulse in a sticky pending flag. The flag is set even while the source or the global enable is off.
- A level source has no flag. It requests only while its input is high.

A per-source enable register and a global enable bit gate the requests. The lowest index wins. When the core accepts a vector with `ack`, the controller clears the global enable and the flag of the accepted event source. A return strobe sets the global enable again.

After a return, one instruction of the interrupted program must retire before any further vectoring. A two-state sequencer enforces this:

- `SEQ_ARMED`: requests may be raised.
- `SEQ_GAP`: requests are held off.

The sequencer makes these transitions:

- **enter_gap**: ARMED to GAP on `reti`.
- **release**: GAP to ARMED on a `retire` strobe in a later cycle, with no `reti` in that cycle.
- **rearm_gap**: GAP to GAP on a further `reti`.
- **hold**: the state is kept in every other case.

Software can also set or clear the global enable directly, for example to allow nested interrupts inside a handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending flags, all per-source enables and the global enable are 0, `irq_req` is 0 and the sequencer is in SEQ_ARMED.
- R2: An event source (its bit in `LEVEL_MASK` is 0) sets its flag (bit i of `flags_o`) on the clock edge after a cycle with `src_in[i]`=1. This happens regardless of the per-source enable or the global enable.
- R3: A cycle with `clr_wr`=1 clears every flag whose bit in `clr_mask` is 1, and leaves the other flags alone. If an event arrives on a source in the same cycle that its flag is cleared, the flag stays set.
- R4: A level source (its bit in `LEVEL_MASK` is 1) never shows a flag. It requests only in cycles where `src_in[i]`=1. A level input that drops before its enable is set leaves no trace.
- R5: `irq_req` is 1 only when all of the following hold: the global enable is 1, `gie_clr` is 0 in that cycle, the sequencer is in SEQ_ARMED, and at least one source is both pending and enabled. The enable register is loaded from `en_wdata` on a cycle with `en_wr`=1.
- R6: `irq_vec` is the binary index of the lowest-numbered source that is both pending and enabled.
- R7: A cycle with `ack`=1 and `irq_req`=1 clears the global enable and clears the flag of the index shown on `irq_vec`, both at the next edge. An `ack` while `irq_req`=0 changes nothing.
- R8: `reti`=1 sets the global enable and moves the sequencer to SEQ_GAP. No request is raised until a cycle after the `reti` cycle in which `retire`=1; the sequencer is back in SEQ_ARMED on the following edge.
- R9: `gie_set` sets the global enable and `gie_clr` clears it at the next edge. If both arrive together, the clear wins. `gie_clr` also blocks `irq_req` in its own cycle.
- R10: Several flags that become pending while the global enable is off are vectored one at a time, in ascending index order, across successive entry and return sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Event pulses or level conditions, one bit per source |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | NSRC | New per-source enable values |
| clr_wr | input | 1 | Write strobe for flag clearing |
| clr_mask | input | NSRC | A 1 in a bit clears that flag |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable, effective in the same cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| retire | input | 1 | Instruction-retired strobe from the core |
| ack | input | 1 | Core accepts the current vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | IDXW | Binary index of the winning source |
| gie_o | output | 1 | Current global enable |
| flags_o | output | NSRC | Pending flags; bits of level sources always read 0 |

## Verification
The hardest situations to reach from the ports are races within a single cycle:

- an event arriving in the cycle its flag is cleared;
- an event or a pending request meeting a `gie_clr`;
- `gie_set` and `gie_clr` in the same cycle;
- the post-return gap with flags already queued.

The bench reaches these by driving the colliding strobes in the same cycle. For the gap, it fills several flags while the global enable is off, then holds `retire` low for several cycles after `reti` before releasing it. At negedge the bench answers every raised request with `ack`, so entry, return and priority ordering follow one another back to back. A behavioural model is compared against all outputs on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [0:0] {
        SEQ_ARMED = 1'b0,
        SEQ_GAP   = 1'b1
    } seq_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int unsigned     NSRC       = 8,
    parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NSRC-1:0] take_hot,
    output logic [NSRC-1:0] flags_q,
    output logic [NSRC-1:0] active
);

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend_raw;
    logic [NSRC-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_level
            assign flags_q[i]  = 1'b0;
            assign pend_raw[i] = src_in[i];
        end else begin : g_event
            logic flag_r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_r <= 1'b0;
                end else if (src_in[i]) begin
                    flag_r <= 1'b1;
                end else if (clr_eff[i] || take_hot[i]) begin
                    flag_r <= 1'b0;
                end
            end
            assign flags_q[i]  = flag_r;
            assign pend_raw[i] = flag_r;
        end
    end

    assign active = pend_raw & en_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NSRC = 8,
    parameter int unsigned IDXW = 3
) (
    input  logic [NSRC-1:0] active,
    output logic            any,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                idx = IDXW'(i);
            end
        end
    end

    assign any = |active;

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic reti,
    input  logic retire,
    input  logic take,
    output logic gie_q,
    output logic armed
);

    seq_state_e state_q, state_d;
    logic       gie_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_ARMED;
            gie_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            gie_q   <= gie_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_ARMED: if (reti) state_d = SEQ_GAP;
            SEQ_GAP: begin
                if (reti)        state_d = SEQ_GAP;
                else if (retire) state_d = SEQ_ARMED;
            end
            default: state_d = SEQ_ARMED;
        endcase
    end

    always_comb begin
        gie_d = gie_q;
        if (gie_set || reti) gie_d = 1'b1;
        if (gie_clr || take) gie_d = 1'b0;
        armed = (state_q == SEQ_ARMED);
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int unsigned     NSRC       = 8,
    parameter logic [NSRC-1:0] LEVEL_MASK = 8'hC0,
    parameter int unsigned     IDXW       = irq_pkg::idx_width(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            gie_set,
    input  logic            gie_clr,
    input  logic            reti,
    input  logic            retire,
    input  logic            ack,
    output logic            irq_req,
    output logic [IDXW-1:0] irq_vec,
    output logic            gie_o,
    output logic [NSRC-1:0] flags_o
);

    logic [NSRC-1:0] active;
    logic [NSRC-1:0] take_hot;
    logic            any;
    logic            armed;
    logic            take;
    logic [IDXW-1:0] win_idx;

    irq_src_bank #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .take_hot (take_hot),
        .flags_q  (flags_o),
        .active   (active)
    );

    irq_prio_enc #(.NSRC(NSRC), .IDXW(IDXW)) u_enc (
        .active (active),
        .any    (any),
        .idx    (win_idx)
    );

    irq_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .gie_set (gie_set),
        .gie_clr (gie_clr),
        .reti    (reti),
        .retire  (retire),
        .take    (take),
        .gie_q   (gie_o),
        .armed   (armed)
    );

    assign irq_req  = gie_o && armed && any && !gie_clr;
    assign irq_vec  = win_idx;
    assign take     = ack && irq_req;
    assign take_hot = take ? (NSRC'(1) << win_idx) : '0;

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
    parameter int unsigned     NSRC       = 8,
    parameter logic [NSRC-1:0] LEVEL_MASK = 8'hC0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_in,
    input logic            gie_clr,
    input logic            reti,
    input logic            ack,
    input logic            irq_req,
    input logic            gie_o,
    input logic [NSRC-1:0] flags_o
);

    logic [NSRC-1:0] ev_in;
    assign ev_in = src_in & ~LEVEL_MASK;

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (gie_o && !gie_clr)); // R5

    AST_GAP_AFTER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_req); // R8

    AST_ENTRY_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> !gie_o); // R7

    AST_CLEAR_GIE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !gie_o); // R9

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_in) |=> ((flags_o & $past(ev_in)) == $past(ev_in))); // R2

endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_in),
    .gie_clr (gie_clr),
    .reti    (reti),
    .ack     (ack),
    .irq_req (irq_req),
    .gie_o   (gie_o),
    .flags_o (flags_o)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    localparam int unsigned NSRC = 8;
    localparam int unsigned IDXW = 3;
    localparam logic [7:0]  LVL  = 8'hC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] src_in = '0, en_wdata = '0, clr_mask = '0;
    logic en_wr = 0, clr_wr = 0, gie_set = 0, gie_clr = 0;
    logic reti = 0, retire = 0, ack = 0;
    logic irq_req, gie_o;
    logic [IDXW-1:0] irq_vec;
    logic [7:0] flags_o;

    prio_irq_ctrl #(.NSRC(NSRC), .LEVEL_MASK(LVL)) dut (.*);

    always #5 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;
    string cur = "R1";
    bit auto_ack = 0;

    // behavioural model state
    logic [7:0] m_flag = '0, m_en = '0;
    bit m_gie = 0, m_gap = 0;
    // last observed outputs
    logic obs_req; logic [IDXW-1:0] obs_vec; logic obs_gie; logic [7:0] obs_flags;
    int taken[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
        if (v == 0) lowest = 0;
    endfunction

    task automatic cyc();
        logic [7:0] act;
        bit exp_req, tk;
        int ev;
        @(negedge clk);
        act = ((m_flag & ~LVL) | (src_in & LVL)) & m_en;
        exp_req = m_gie && !m_gap && (act != 0) && !gie_clr;
        ev = lowest(act);
        obs_req = irq_req; obs_vec = irq_vec; obs_gie = gie_o; obs_flags = flags_o;
        chk(irq_req == exp_req, {cur, " irq_req"}, irq_req, exp_req);
        if (exp_req) chk(int'(irq_vec) == ev, {cur, " irq_vec"}, irq_vec, ev);
        chk(gie_o == m_gie, {cur, " gie_o"}, gie_o, m_gie);
        chk(flags_o == m_flag, {cur, " flags_o"}, flags_o, m_flag);
        if (auto_ack) ack = irq_req;
        @(posedge clk);
        tk = ack && exp_req;
        if (tk) taken.push_back(ev);
        m_flag = m_flag & ~(clr_wr ? clr_mask : 8'h00) & ~(tk ? (8'h01 << ev) : 8'h00);
        m_flag = m_flag | (src_in & ~LVL);
        if (en_wr) m_en = en_wdata;
        if (gie_set || reti) m_gie = 1;
        if (gie_clr || tk) m_gie = 0;
        if (reti) m_gap = 1; else if (m_gap && retire) m_gap = 0;
        #1;
        src_in = '0; en_wr = 0; clr_wr = 0; gie_set = 0; gie_clr = 0;
        reti = 0; retire = 0; ack = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        cur = "R1"; cyc();
        chk(obs_flags == 0 && !obs_gie && !obs_req, "R1 reset", {obs_flags, obs_gie, obs_req}, 0);

        // R2 events latch while everything is disabled
        cur = "R2"; src_in = 8'h28; cyc(); cyc();
        chk(obs_flags == 8'h28, "R2 flags set", obs_flags, 8'h28);

        // R3 W1C, same-cycle event wins on bit 3
        cur = "R3"; clr_wr = 1; clr_mask = 8'h28; src_in = 8'h08; cyc(); cyc();
        chk(obs_flags == 8'h08, "R3 clear/event race", obs_flags, 8'h08);

        // R5 source 3 pending but its enable is off
        cur = "R5"; en_wr = 1; en_wdata = 8'hF7; gie_set = 1; cyc(); cyc();
        chk(!obs_req, "R5 disabled source", obs_req, 0);

        // R6 lowest index among enabled pending
        cur = "R6"; src_in = 8'h12; cyc(); cyc();
        chk(obs_req && obs_vec == 1, "R6 vector", obs_vec, 1);

        // R7 entry clears gie and taken flag
        cur = "R7"; auto_ack = 1; cyc(); auto_ack = 0; cyc();
        chk(!obs_gie && obs_flags == 8'h18, "R7 entry", {obs_gie, obs_flags}, 8'h18);
        // R7 ack with no request has no effect
        ack = 1; cyc(); cyc();
        chk(obs_flags == 8'h18 && !obs_gie, "R7 stray ack", obs_flags, 8'h18);

        // R8 post-return gap
        cur = "R8"; reti = 1; cyc(); idle(3);
        chk(!obs_req && obs_gie, "R8 gap holds", obs_req, 0);
        retire = 1; cyc(); cyc();
        chk(obs_req && obs_vec == 4, "R8 released", obs_vec, 4);

        // R10 ordered servicing of queued flags
        cur = "R10"; gie_clr = 1; cyc();
        src_in = 8'h05; cyc();
        en_wr = 1; en_wdata = 8'hFF; cyc();
        taken.delete();
        gie_set = 1; cyc();
        for (int k = 0; k < 4; k++) begin
            auto_ack = 1; cyc(); auto_ack = 0;
            reti = 1; cyc(); retire = 1; cyc();
        end
        chk(taken.size() == 4, "R10 count", taken.size(), 4);
        if (taken.size() == 4)
            chk(taken[0] == 0 && taken[1] == 2 && taken[2] == 3 && taken[3] == 4,
                "R10 order", taken[0] * 1000 + taken[1] * 100 + taken[2] * 10 + taken[3], 234);

        // R4 level source: requests while high, no flag, lost when disabled
        cur = "R4"; src_in = 8'h40; cyc(); src_in = 8'h40; cyc();
        chk(obs_req && obs_vec == 6 && obs_flags[6] == 0, "R4 level req", obs_vec, 6);
        cyc();
        chk(!obs_req, "R4 level gone", obs_req, 0);
        en_wr = 1; en_wdata = 8'hBF; src_in = 8'h40; cyc();
        en_wr = 1; en_wdata = 8'hFF; cyc(); cyc();
        chk(!obs_req && obs_flags == 0, "R4 lost", {obs_req, obs_flags}, 0);

        // R9 clear blocks same-cycle request, clear wins over set
        cur = "R9"; src_in = 8'h01; gie_clr = 1; cyc();
        chk(!obs_req, "R9 clr+event", obs_req, 0);
        gie_set = 1; gie_clr = 1; cyc(); cyc();
        chk(!obs_gie, "R9 clear wins", obs_gie, 0);
        gie_set = 1; cyc(); gie_clr = 1; cyc();
        chk(!obs_req, "R9 immediate clear", obs_req, 0);
        // nesting: handler re-enables globally
        gie_set = 1; cyc(); auto_ack = 1; cyc(); auto_ack = 0;
        src_in = 8'h02; gie_set = 1; cyc(); cyc();
        chk(obs_req && obs_vec == 1, "R9 nested req", obs_vec, 1);
        auto_ack = 1; cyc(); auto_ack = 0; idle(2);

        finish_run();
    end

endmodule